// File: doc/BRIEF.md
# Paired-Table Sequential Element

This block takes the two outputs of an even/odd pair of lookup tables and produces one output bit. That bit can be combinational, registered or latched. A two-bit mode select chooses among four behaviours at run time: a plain pass-through of the even output, a gated D flip-flop, a JK flip-flop and a gated D-latch. The flip-flop advances only on rising edges of a dedicated logic clock. The latch is level-sensitive on the odd table output.

The element clears itself when the even table of the pair is switched off. A small circuit in the bus-clock domain detects the falling edge of the table-enable bit. It then raises a clear for exactly one bus-clock cycle, and that clear acts asynchronously on both storage elements. A synchronous, active-high system reset also brings the output to 0 at power-on.

Top module: `lutseq_pair`

## Requirements
- R1: A falling edge of `tbl_en`, sampled on `bclk`, clears both the flip-flop state and the latch state to 0, whatever the logic clock is doing.
- R2: The internal clear lasts exactly one `bclk` cycle. After it ends, the flip-flop resumes normal updates on the next `lclk` rising edge.
- R3: Mode encoding 2'b00 (bypass): `seq_out` equals `lut_even` combinationally.
- R4: Mode 2'b01 (gated DFF): on a rising `lclk` edge with `lut_odd`=1, the state takes `lut_even`. With `lut_odd`=0 the state holds.
- R5: Mode 2'b10 (JK, J=`lut_even`, K=`lut_odd`): on a rising `lclk` edge, 00 holds, 01 clears, 10 sets and 11 inverts the state.
- R6: Mode 2'b11 (gated latch): while `lut_odd`=1, `seq_out` follows `lut_even`. While `lut_odd`=0, it keeps the last value passed.
- R7: A change of mode leaves the stored flip-flop and latch values untouched. On return to a flop mode, the output shows the value held before the detour.
- R8: A high `rst` sampled on `lclk` clears the flip-flop, and `rst` clears the latch, so `seq_out` reads 0 after reset in every storage mode.
- R9: In the flop modes, `seq_out` does not change between `lclk` rising edges, even when `lut_even` and `lut_odd` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock; the enable edge detector runs on it |
| lclk | input | 1 | Dedicated logic clock for the flip-flop |
| rst | input | 1 | Synchronous active-high system reset |
| tbl_en | input | 1 | Enable bit of the even lookup table |
| lut_even | input | 1 | Even table output (D or J) |
| lut_odd | input | 1 | Odd table output (gate or K) |
| mode_sel | input | 2 | Behaviour select: 00 bypass, 01 DFF, 10 JK, 11 latch |
| seq_out | output | 1 | Element output |

## Verification
Several properties are checked on every cycle. A falling enable must be followed by a clear on the next bus edge, and that clear must drop after one cycle. Both inputs high in JK mode must invert the state. A closed gate in DFF mode must leave the state alone. An open gate in latch mode must make the latch value equal the even input. Other behaviours need scenarios the bench builds. These include state that survives a detour through bypass and latch modes, the stillness of the output between logic-clock edges, and the full clear-then-resume sequence across the two clock domains. The bench checks these against its own model of the flop and latch.

// File: rtl/lutseq_pkg.sv
package lutseq_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'b00,
        MODE_DFF    = 2'b01,
        MODE_JK     = 2'b10,
        MODE_LATCH  = 2'b11
    } mode_e;

    typedef struct packed {
        logic even;
        logic odd;
    } pair_t;

    localparam int unsigned CLR_WIDTH_CYCLES = 1;

    function automatic logic jk_next(input logic q, input logic j, input logic k);
        logic r;
        unique case ({j, k})
            2'b00:   r = q;
            2'b01:   r = 1'b0;
            2'b10:   r = 1'b1;
            default: r = ~q;
        endcase
        return r;
    endfunction

    function automatic logic flop_next(input mode_e m, input pair_t p, input logic q);
        logic r;
        unique case (m)
            MODE_DFF: r = p.odd ? p.even : q;
            MODE_JK:  r = jk_next(q, p.even, p.odd);
            default:  r = q;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lutseq_clrgen.sv
module lutseq_clrgen
    import lutseq_pkg::*;
(
    input  logic bclk,
    input  logic rst,
    input  logic tbl_en,
    output logic clr
);

    logic en_q;

    always_ff @(posedge bclk) begin
        if (rst) begin
            en_q <= 1'b0;
            clr  <= 1'b0;
        end else begin
            en_q <= tbl_en;
            clr  <= en_q & ~tbl_en;
        end
    end

    AST_CLR_AFTER_FALL: assert property (@(posedge bclk) disable iff (rst)
        $fell(tbl_en) |=> clr); // R1

    AST_CLR_SINGLE: assert property (@(posedge bclk) disable iff (rst)
        clr |=> !clr); // R2

endmodule

// File: rtl/lutseq_core.sv
module lutseq_core
    import lutseq_pkg::*;
(
    input  logic  lclk,
    input  logic  rst,
    input  logic  clr,
    input  mode_e mode,
    input  pair_t pair,
    output logic  q_ff,
    output logic  q_lat
);

    always_ff @(posedge lclk or posedge clr) begin
        if (clr) begin
            q_ff <= 1'b0;
        end else if (rst) begin
            q_ff <= 1'b0;
        end else begin
            q_ff <= flop_next(mode, pair, q_ff);
        end
    end

    always_latch begin
        if (rst || clr) begin
            q_lat = 1'b0;
        end else if (mode == MODE_LATCH && pair.odd) begin
            q_lat = pair.even;
        end
    end

    AST_JK_TOGGLE: assert property (@(posedge lclk) disable iff (rst || clr)
        (mode == MODE_JK && pair.even && pair.odd) |=> (q_ff != $past(q_ff))); // R5

    AST_DFF_HOLD: assert property (@(posedge lclk) disable iff (rst || clr)
        (mode == MODE_DFF && !pair.odd) |=> $stable(q_ff)); // R4

    AST_LATCH_PASS: assert property (@(posedge lclk) disable iff (rst || clr)
        (mode == MODE_LATCH && pair.odd) |-> (q_lat == pair.even)); // R6

endmodule

// File: rtl/lutseq_pair.sv
module lutseq_pair
    import lutseq_pkg::*;
(
    input  logic       bclk,
    input  logic       lclk,
    input  logic       rst,
    input  logic       tbl_en,
    input  logic       lut_even,
    input  logic       lut_odd,
    input  logic [1:0] mode_sel,
    output logic       seq_out
);

    logic  clr;
    logic  q_ff;
    logic  q_lat;
    mode_e mode;
    pair_t pair;

    assign mode      = mode_e'(mode_sel);
    assign pair.even = lut_even;
    assign pair.odd  = lut_odd;

    lutseq_clrgen u_clrgen (
        .bclk   (bclk),
        .rst    (rst),
        .tbl_en (tbl_en),
        .clr    (clr)
    );

    lutseq_core u_core (
        .lclk  (lclk),
        .rst   (rst),
        .clr   (clr),
        .mode  (mode),
        .pair  (pair),
        .q_ff  (q_ff),
        .q_lat (q_lat)
    );

    always_comb begin
        unique case (mode)
            MODE_BYPASS: seq_out = pair.even;
            MODE_LATCH:  seq_out = q_lat;
            default:     seq_out = q_ff;
        endcase
    end

endmodule

// File: tb/sim_lutseq_pair.sv
module sim_lutseq_pair;

    logic       bclk = 1'b0;
    logic       lclk = 1'b0;
    logic       rst = 1'b1;
    logic       tbl_en = 1'b1;
    logic       lut_even = 1'b0;
    logic       lut_odd = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic       seq_out;

    int total = 0;
    int bad = 0;
    logic m_ff = 1'b0;
    logic m_lat = 1'b0;

    always #4 lclk = ~lclk;
    always #7 bclk = ~bclk;

    lutseq_pair u0 (
        .bclk     (bclk),
        .lclk     (lclk),
        .rst      (rst),
        .tbl_en   (tbl_en),
        .lut_even (lut_even),
        .lut_odd  (lut_odd),
        .mode_sel (mode_sel),
        .seq_out  (seq_out)
    );

    function automatic logic model_flop(input logic [1:0] m, input logic d, input logic g, input logic q);
        if (m == 2'b01) return g ? d : q;
        if (m == 2'b10) begin
            case ({d, g})
                2'b00:   return q;
                2'b01:   return 1'b0;
                2'b10:   return 1'b1;
                default: return ~q;
            endcase
        end
        return q;
    endfunction

    function automatic logic model_out(input logic [1:0] m, input logic d);
        if (m == 2'b00) return d;
        if (m == 2'b11) return m_lat;
        return m_ff;
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic [1:0] m, input logic d, input logic g);
        @(negedge lclk);
        mode_sel = m;
        lut_even = d;
        lut_odd  = g;
        if (m == 2'b11 && g) m_lat = d;
        @(posedge lclk);
        m_ff = model_flop(m, d, g, m_ff);
        #1;
        chk(tag, seq_out, model_out(m, d));
    endtask

    task automatic disable_table();
        @(negedge lclk);
        mode_sel = 2'b01;
        lut_odd  = 1'b0;
        tbl_en   = 1'b0;
        @(posedge bclk);
        @(posedge bclk);
        m_ff  = 1'b0;
        m_lat = 1'b0;
        @(negedge lclk);
        chk("R1 flop cleared", seq_out, 1'b0);
        mode_sel = 2'b11;
        #1;
        chk("R1 latch cleared", seq_out, 1'b0);
        tbl_en = 1'b1;
        @(posedge bclk);
        @(posedge bclk);
    endtask

    initial begin
        #1200000;
        bad++;
        total++;
        $display("FAIL watchdog: got=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge bclk);
        @(negedge lclk);
        rst = 1'b0;
        #1;
        chk("R8 reset flop", seq_out, 1'b0);
        mode_sel = 2'b11;
        #1;
        chk("R8 reset latch", seq_out, 1'b0);

        step("R3 bypass one", 2'b00, 1'b1, 1'b0);
        step("R3 bypass zero", 2'b00, 1'b0, 1'b1);

        step("R4 dff load 1", 2'b01, 1'b1, 1'b1);
        step("R4 dff hold", 2'b01, 1'b0, 1'b0);
        step("R4 dff load 0", 2'b01, 1'b0, 1'b1);

        step("R5 jk set", 2'b10, 1'b1, 1'b0);
        step("R5 jk hold", 2'b10, 1'b0, 1'b0);
        step("R5 jk toggle", 2'b10, 1'b1, 1'b1);
        step("R5 jk toggle back", 2'b10, 1'b1, 1'b1);
        step("R5 jk clear", 2'b10, 1'b0, 1'b1);

        step("R6 latch pass 1", 2'b11, 1'b1, 1'b1);
        step("R6 latch hold", 2'b11, 1'b0, 1'b0);
        step("R6 latch pass 0", 2'b11, 1'b0, 1'b1);

        step("R7 load before detour", 2'b01, 1'b1, 1'b1);
        step("R7 bypass detour", 2'b00, 1'b0, 1'b0);
        step("R7 latch detour", 2'b11, 1'b1, 1'b0);
        step("R7 back to jk", 2'b10, 1'b0, 1'b0);

        @(negedge lclk);
        mode_sel = 2'b01;
        lut_even = 1'b0;
        lut_odd  = 1'b1;
        #2;
        chk("R9 no change between edges", seq_out, m_ff);
        @(posedge lclk);
        m_ff = 1'b0;
        #1;
        chk("R9 update at edge", seq_out, 1'b0);

        step("R4 set before clear", 2'b01, 1'b1, 1'b1);
        step("R6 latch set before clear", 2'b11, 1'b1, 1'b1);
        disable_table();
        step("R2 resume after clear", 2'b01, 1'b1, 1'b1);
        step("R2 jk after clear", 2'b10, 1'b1, 1'b1);

        for (int i = 0; i < 400; i++) begin
            if (($urandom % 25) == 0) begin
                disable_table();
            end else begin
                step("R4 R5 R6 random", 2'($urandom), 1'($urandom), 1'($urandom));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule